// File: doc/BRIEF.md
# Multiprocessor-Capable Serial Frame Receiver

This block receives asynchronous serial frames on a single line and hands them to a host. The line is oversampled sixteen times per bit under a baud-tick enable. The block collects either eight data bits, or eight data bits followed by a ninth bit, and checks the stop bit. Each finished frame goes into a two-entry first-in first-out buffer. The host sees the oldest entry on its outputs and removes it with a one-cycle read strobe. An interrupt line stays high for as long as anything is waiting in the buffer.

In nine-bit mode the receiver can act as a multiprocessor address filter. When this filter is on, a frame is kept only if its ninth bit is 1, so a node wakes up only on address frames. When the filter is off, the ninth bit is handed to software unchanged, and software may treat it as a parity or address marker. The hardware never computes parity. A bad stop bit is recorded with the frame it belongs to. A frame that arrives while the buffer is full sets a sticky overrun flag. That flag blocks all further reception until software drops the receive enable.

Top module: `uart9_rx`

## Requirements
- R1: While `port_en` is 0 the block is held cleared: the buffer is emptied, `rx_irq`, `overrun_err` and `framing_err` are 0, and nothing is received. The same state follows a low `rst_n`.
- R2: A frame is one low start bit, then data bits least significant bit first, then one stop bit, each bit lasting 16 baud ticks. With `nine_bit_mode` at 0 there are 8 data bits, the byte appears on `rx_data`, and `rx_bit9` reads 0.
- R3: With `nine_bit_mode` at 1 a ninth bit is received after data bit 7 and appears on `rx_bit9` next to its byte.
- R4: With `nine_bit_mode` and `addr_detect` both 1, a frame whose ninth bit is 0 is dropped: the buffer, `rx_irq` and `overrun_err` stay as they were. A frame whose ninth bit is 1 is stored.
- R5: With `addr_detect` at 0, or with `nine_bit_mode` at 0, every frame is stored and the ninth bit is passed through as received.
- R6: A stop bit sampled as 0 stores the frame with its framing flag set. `framing_err` shows the flag of the oldest stored frame and is 0 while the buffer is empty.
- R7: The buffer holds two frames and returns them in arrival order. `rx_irq` is 1 exactly while it is non-empty. Each cycle with `rd_strobe` at 1 removes one entry, and a strobe on an empty buffer has no effect.
- R8: A frame that would be stored while both entries are full, with no read in the same cycle, is lost and sets `overrun_err`. While the flag is set no frame is stored, even if space has been freed. Only `rx_enable` at 0 (or R1) clears the flag.
- R9: While `rx_enable` is 0 no frame is received, but the frames already stored stay readable.
- R10: If a frame completes while the buffer is full and `rd_strobe` is 1 in that same cycle, the oldest entry is removed, the new frame is stored, and `overrun_err` stays 0.
- R11: Nothing advances while `baud_tick` is 0. A low on the line that is gone by the middle of the start bit (8 ticks after it is first seen) is ignored.
- R12: With `baud_tick` held at 1 and `rx_in` driven low just before rising clock edge 1, a frame with B data bits (8 or 9) reaches an empty buffer at rising edge 16*B+28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Receiver enable; 0 holds the whole block cleared |
| nine_bit_mode | input | 1 | 1 selects nine data bits per frame, 0 selects eight |
| rx_enable | input | 1 | Reception enable; 0 also clears the overrun flag |
| addr_detect | input | 1 | In nine-bit mode, keep only frames whose ninth bit is 1 |
| baud_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_in | input | 1 | Serial line, idles high |
| rd_strobe | input | 1 | Removes the oldest buffered frame |
| rx_data | output | 8 | Data byte of the oldest buffered frame |
| rx_bit9 | output | 1 | Ninth bit of the oldest buffered frame |
| framing_err | output | 1 | Stop-bit error flag of the oldest buffered frame |
| overrun_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | High while the buffer holds at least one frame |

## Verification
Two events can land on the same clock edge: a frame finishing its stop bit and the host removing the oldest entry. When the buffer is full, the outcome decides between a clean store and an overrun. The bench uses the fixed latency of R12 to place a one-cycle read strobe on exactly the edge where a third frame completes. It then expects `overrun_err` to stay 0, the second frame to become the head, and both entries to remain occupied. A separate run fills the buffer and sends a third frame with no read, and it expects the opposite result.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    // One received frame as it travels from the assembler into the buffer.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit9;
        logic              ferr;
    } rx_frame_t;

endpackage

// File: rtl/uart9_rx_sync.sv
module uart9_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_s;

    sync_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.sh = '1;
        end else begin
            st_d.sh = {st_q.sh[STAGES-2:0], d};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sh: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.sh[STAGES-1];

endmodule

// File: rtl/uart9_rx_frame.sv
module uart9_rx_frame
    import uart9_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      tick,
    input  logic      rx,
    input  logic      nine_mode,
    output logic      done,
    output rx_frame_t frame
);

    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int IDX_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W:0]   shift;
        logic              done;
        rx_frame_t         frame;
    } frm_s;

    frm_s st_d, st_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = nine_mode ? IDX_W'(BYTE_W) : IDX_W'(BYTE_W - 1);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d.state = ST_IDLE;
            st_d.cnt   = '0;
            st_d.idx   = '0;
        end else if (tick) begin
            unique case (st_q.state)
                ST_IDLE: begin
                    if (!rx) begin
                        st_d.state = ST_START;
                        st_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (st_q.cnt == MID_CNT) begin
                        st_d.cnt = '0;
                        st_d.idx = '0;
                        // A line back high at mid start bit was a glitch.
                        st_d.state = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt              = '0;
                        st_d.shift[st_q.idx]  = rx;
                        if (st_q.idx == last_idx) begin
                            st_d.state = ST_STOP;
                        end else begin
                            st_d.idx = st_q.idx + 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (st_q.cnt == LAST_CNT) begin
                        st_d.cnt        = '0;
                        st_d.state      = ST_IDLE;
                        st_d.done       = 1'b1;
                        st_d.frame.data = st_q.shift[BYTE_W-1:0];
                        st_d.frame.bit9 = nine_mode & st_q.shift[BYTE_W];
                        st_d.frame.ferr = ~rx;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, idx: '0, shift: '0,
                      done: 1'b0, frame: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done  = st_q.done;
    assign frame = st_q.frame;

endmodule

// File: rtl/uart9_rx_buf.sv
module uart9_rx_buf
    import uart9_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      ovr_clr,
    input  logic      push_req,
    input  rx_frame_t push_frame,
    input  logic      pop_req,
    output rx_frame_t head,
    output logic      not_empty,
    output logic      overrun
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        rx_frame_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      rd_ptr;
        logic [PTR_W-1:0]      wr_ptr;
        logic [CNT_W-1:0]      count;
        logic                  ovr;
    } buf_s;

    buf_s st_d, st_q;
    logic pop_ok, push_ok, is_full;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        is_full = (st_q.count == FULL_CNT);
        pop_ok  = pop_req && (st_q.count != '0);
        push_ok = 1'b0;
        if (push_req && !st_q.ovr) begin
            if (!is_full || pop_ok) begin
                push_ok = 1'b1;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
        if (push_ok) begin
            st_d.mem[st_q.wr_ptr] = push_frame;
            st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
        end
        if (pop_ok) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        st_d.count = st_q.count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (ovr_clr) begin
            st_d.ovr = 1'b0;
        end
        if (clr) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.count  = '0;
            st_d.ovr    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mem: '0, rd_ptr: '0, wr_ptr: '0, count: '0, ovr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rd_ptr];
    assign not_empty = (st_q.count != '0);
    assign overrun   = st_q.ovr;

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int BUF_DEPTH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              nine_bit_mode,
    input  logic              rx_enable,
    input  logic              addr_detect,
    input  logic              baud_tick,
    input  logic              rx_in,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              framing_err,
    output logic              overrun_err,
    output logic              rx_irq
);

    logic      rx_s;
    logic      frm_done;
    rx_frame_t frm_q;
    rx_frame_t head;
    logic      buf_valid;
    logic      frame_keep;
    logic      port_off;
    logic      rx_off;

    assign port_off = ~port_en;
    assign rx_off   = ~port_en | ~rx_enable;

    uart9_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (port_off),
        .d     (rx_in),
        .q     (rx_s)
    );

    uart9_rx_frame #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_off),
        .tick      (baud_tick),
        .rx        (rx_s),
        .nine_mode (nine_bit_mode),
        .done      (frm_done),
        .frame     (frm_q)
    );

    // Address filter: only meaningful when nine-bit frames are selected.
    assign frame_keep = ~(nine_bit_mode & addr_detect) | frm_q.bit9;

    uart9_rx_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (port_off),
        .ovr_clr    (~rx_enable),
        .push_req   (frm_done & frame_keep),
        .push_frame (frm_q),
        .pop_req    (rd_strobe),
        .head       (head),
        .not_empty  (buf_valid),
        .overrun    (overrun_err)
    );

    assign rx_data     = head.data;
    assign rx_bit9     = head.bit9;
    assign framing_err = head.ferr & buf_valid;
    assign rx_irq      = buf_valid;

endmodule

// File: rtl/uart9_rx_checks.sv
module uart9_rx_checks (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic rx_enable,
    input logic nine_bit_mode,
    input logic addr_detect,
    input logic frm_done,
    input logic frm_bit9,
    input logic framing_err,
    input logic overrun_err,
    input logic rx_irq
);

    assert_port_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!rx_irq && !overrun_err && !framing_err));

    assert_plain_bit9_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !$past(nine_bit_mode)) |-> !frm_bit9);

    assert_addr_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && nine_bit_mode && addr_detect && !frm_bit9 && !rx_irq) |=> !rx_irq);

    assert_ferr_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        framing_err |-> rx_irq);

    assert_space_no_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !overrun_err && !rx_irq) |=> !overrun_err);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && rx_enable && port_en) |=> overrun_err);

    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !overrun_err);

endmodule

bind uart9_rx uart9_rx_checks u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_en       (port_en),
    .rx_enable     (rx_enable),
    .nine_bit_mode (nine_bit_mode),
    .addr_detect   (addr_detect),
    .frm_done      (frm_done),
    .frm_bit9      (frm_q.bit9),
    .framing_err   (framing_err),
    .overrun_err   (overrun_err),
    .rx_irq        (rx_irq)
);

// File: tb/uart9_rx_test.sv
module uart9_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       rx_enable = 1'b0;
    logic       addr_detect = 1'b0;
    logic       baud_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       framing_err;
    logic       overrun_err;
    logic       rx_irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Model entry: {ferr, bit9, data}
    logic [9:0] model_q[$];
    logic       model_ovr = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart9_rx uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_en       (port_en),
        .nine_bit_mode (nine_bit_mode),
        .rx_enable     (rx_enable),
        .addr_detect   (addr_detect),
        .baud_tick     (baud_tick),
        .rx_in         (rx_in),
        .rd_strobe     (rd_strobe),
        .rx_data       (rx_data),
        .rx_bit9       (rx_bit9),
        .framing_err   (framing_err),
        .overrun_err   (overrun_err),
        .rx_irq        (rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic keep_frame(input logic nine, input logic adden, input logic b9);
        return !(nine && adden) || b9;
    endfunction

    task automatic model_push(input logic [7:0] d, input logic b9, input logic fe);
        logic eb9;
        eb9 = nine_bit_mode ? b9 : 1'b0;
        if (!port_en || !rx_enable || !baud_tick) return;
        if (!keep_frame(nine_bit_mode, addr_detect, eb9)) return;
        if (model_ovr) return;
        if (model_q.size() < DEPTH) model_q.push_back({fe, eb9, d});
        else model_ovr = 1'b1;
    endtask

    task automatic check_state(input string req);
        chk(req, rx_irq, model_q.size() != 0);
        chk(req, overrun_err, model_ovr);
        if (model_q.size() != 0) begin
            chk(req, rx_data, model_q[0][7:0]);
            chk(req, rx_bit9, model_q[0][8]);
            chk(req, framing_err, model_q[0][9]);
        end else begin
            chk(req, framing_err, 1'b0);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends one frame; rd_at >= 0 pulses rd_strobe at that drive slot.
    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_ok,
                              input int rd_at, output int irq_j);
        int nb;
        logic v;
        nb = nine_bit_mode ? 9 : 8;
        irq_j = -1;
        for (int j = 0; j < 16 * (nb + 2); j++) begin
            int k;
            @(negedge clk);
            if (irq_j < 0 && rx_irq) irq_j = j;
            k = j / 16;
            if (k == 0) v = 1'b0;
            else if (k <= 8) v = d[k-1];
            else if (k <= nb) v = b9;
            else v = stop_ok;
            rx_in     = v;
            rd_strobe = (j == rd_at);
        end
        @(negedge clk);
        rx_in     = 1'b1;
        rd_strobe = 1'b0;
        if (rd_at >= 0 && model_q.size() != 0) void'(model_q.pop_front());
        model_push(d, b9, !stop_ok);
        idle(20);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        if (model_q.size() != 0) void'(model_q.pop_front());
        idle(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        void'($urandom(32'h5EED_1234));

        idle(4);
        chk("R1 reset irq", rx_irq, 1'b0);
        chk("R1 reset ovr", overrun_err, 1'b0);
        chk("R1 reset ferr", framing_err, 1'b0);
        rst_n = 1'b1;
        port_en = 1'b1;
        rx_enable = 1'b1;
        idle(4);

        // R2 / R12: eight-bit frame into an empty buffer
        send_frame(8'hA5, 1'b1, 1'b1, -1, lat);
        chk("R12 latency 8-bit", lat, 16 * 8 + 28);
        check_state("R2 eight-bit frame");
        do_read();
        check_state("R7 read empties");

        // R5: nine-bit, filter off, ninth bit 0 kept
        nine_bit_mode = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b1, -1, lat);
        chk("R5 stored bit9=0", rx_irq, 1'b1);
        check_state("R5 pass-through");
        do_read();

        // R4: filter on, ninth bit 0 dropped
        addr_detect = 1'b1;
        send_frame(8'h11, 1'b0, 1'b1, -1, lat);
        chk("R4 dropped irq", rx_irq, 1'b0);
        check_state("R4 drop");
        // R3 / R4 / R12: ninth bit 1 accepted
        send_frame(8'h81, 1'b1, 1'b1, -1, lat);
        chk("R12 latency 9-bit", lat, 16 * 9 + 28);
        chk("R3 ninth bit", rx_bit9, 1'b1);
        check_state("R4 address frame kept");
        do_read();

        // R5: filter has no effect in eight-bit mode
        nine_bit_mode = 1'b0;
        send_frame(8'h5A, 1'b0, 1'b1, -1, lat);
        chk("R5 eight-bit with filter", rx_irq, 1'b1);
        check_state("R5 filter ignored");
        do_read();
        addr_detect = 1'b0;

        // R6: bad stop bit
        send_frame(8'hC3, 1'b0, 1'b0, -1, lat);
        chk("R6 framing flag", framing_err, 1'b1);
        check_state("R6 framing");
        do_read();
        chk("R6 empty no flag", framing_err, 1'b0);
        do_read();
        check_state("R7 read on empty");

        // R7 / R8: fill, overrun, blocked, clear
        send_frame(8'h01, 1'b0, 1'b1, -1, lat);
        send_frame(8'h02, 1'b0, 1'b1, -1, lat);
        check_state("R7 two stored");
        send_frame(8'h03, 1'b0, 1'b1, -1, lat);
        chk("R8 overrun set", overrun_err, 1'b1);
        check_state("R8 head kept");
        do_read();
        chk("R7 order second", rx_data, 8'h02);
        send_frame(8'h04, 1'b0, 1'b1, -1, lat);
        check_state("R8 blocked while set");
        rx_enable = 1'b0;
        idle(2);
        model_ovr = 1'b0;
        chk("R8 cleared", overrun_err, 1'b0);
        // R9: disabled receiver ignores the line, buffer kept
        send_frame(8'h77, 1'b0, 1'b1, -1, lat);
        check_state("R9 disabled");
        rx_enable = 1'b1;
        idle(2);

        // R10: read on the completion edge with a full buffer
        send_frame(8'h05, 1'b0, 1'b1, -1, lat);
        check_state("R10 setup full");
        send_frame(8'h06, 1'b0, 1'b1, 16 * 8 + 27, lat);
        chk("R10 no overrun", overrun_err, 1'b0);
        chk("R10 new head", rx_data, 8'h05);
        check_state("R10 collision");
        do_read();
        chk("R10 last entry", rx_data, 8'h06);
        do_read();
        check_state("R10 drained");

        // R11: no tick, no progress; short glitch ignored
        baud_tick = 1'b0;
        send_frame(8'h99, 1'b0, 1'b1, -1, lat);
        baud_tick = 1'b1;
        check_state("R11 tick held low");
        @(negedge clk);
        rx_in = 1'b0;
        idle(4);
        rx_in = 1'b1;
        idle(40);
        check_state("R11 glitch");

        // R1: disabling the port clears everything
        send_frame(8'hE7, 1'b0, 1'b1, -1, lat);
        port_en = 1'b0;
        idle(2);
        chk("R1 port off irq", rx_irq, 1'b0);
        port_en = 1'b1;
        idle(2);
        model_q.delete();
        model_ovr = 1'b0;
        check_state("R1 port back on");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            logic [7:0] d;
            logic b9, sok;
            int nrd;
            nine_bit_mode = $urandom_range(0, 1);
            addr_detect   = $urandom_range(0, 1);
            d   = 8'($urandom);
            b9  = $urandom_range(0, 1);
            sok = ($urandom_range(0, 7) != 0);
            send_frame(d, b9, sok, -1, lat);
            check_state("R2 R3 R4 R5 R6 random frame");
            nrd = $urandom_range(0, 2);
            for (int r = 0; r < nrd; r++) do_read();
            check_state("R7 random read");
            if (model_ovr && $urandom_range(0, 1) == 1) begin
                rx_enable = 1'b0;
                idle(2);
                model_ovr = 1'b0;
                rx_enable = 1'b1;
                idle(2);
                check_state("R8 random clear");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule